// File: doc/BRIEF.md
# Windowed Write-Once Watchdog Timer

This block watches a system for loss of control. A slow reference clock, sampled into the system clock domain, drives a prescaler. Every `PRESCALE` rising edges of that reference produce one tick, and each tick steps a 12-bit down counter. Software must restart the counter before it runs out. A restart is a write to the control register that carries the correct key. If the counter runs out, the block raises an underflow flag and can issue a one-cycle reset pulse to the rest of the chip.

The mode register sets the reload value, the restart window, reset enable, debug halt and disable. It accepts exactly one write after reset, so a runaway program cannot reconfigure or switch off the watchdog once boot code has set it. A restart counts only while the counter is at or below the window delta. A restart that arrives early is treated as a fault. With the default prescale of 128 and a 32.768 kHz reference, the counter ticks 256 times per second, and the longest period is 4096 ticks, or 16 seconds.

Address map: 0 is the mode register (read and write-once), 1 is the control register (write only), and 2 is the status register (read, clears its flags).

Top module: `watchdog_window`

## Requirements
- R1: After reset the counter holds 0xFFF, both flags are 0 and `wdtReset` is low. The mode register reads 0x0FFF1FFF: reload 0xFFF, window 0xFFF, reset enable 1, debug halt 0, disable 0.
- R2: While enabled, the counter drops by one for every `PRESCALE` rising edges seen on `slowClk`. Between ticks it holds its value.
- R3: The first write to address 0 after reset loads the mode fields and reloads the counter with the new reload value. Every later write to address 0 changes neither the mode fields nor the counter.
- R4: Mode register layout. Bits 11:0 hold the reload value. Bit 12 is reset enable, bit 13 is debug halt and bit 14 is disable. Bits 27:16 hold the window delta.
- R5: When disable is set, the counter never changes after the mode write, no tick is taken and `wdtReset` stays low. Restarts have no effect.
- R6: A tick taken at count 0 reloads the counter, sets the underflow flag and, only if reset enable is set, drives `wdtReset` high for exactly one clock cycle.
- R7: When debug halt is set and `dbgIn` is high, the counter does not step. If debug halt is clear, `dbgIn` has no effect.
- R8: A restart is a write to address 1 with bit 0 set and 0xA5 in bits 31:24. It reloads the counter. A write to address 1 with a different key, or with bit 0 clear, is ignored.
- R9: A valid keyed restart while the count is above the window delta does not reload the counter. It sets the window-error flag and, if reset enable is set, pulses `wdtReset`. A window delta of 0xFFF accepts a restart at any count.
- R10: Status at address 2 reads underflow in bit 0, window error in bit 1 and the count in bits 27:16. A read clears both flags. A flag event in the same cycle as the read wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| slowClk | input | 1 | Slow reference clock, sampled in the `clk` domain |
| dbgIn | input | 1 | Debug state; high means the processor is halted |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (clears status on address 2) |
| addr | input | 2 | Register address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, combinational from `addr` |
| wdtReset | output | 1 | One-cycle watchdog reset pulse |
| underflowFlag | output | 1 | Sticky underflow flag |
| windowErrFlag | output | 1 | Sticky early-restart flag |

## Verification
The state that matters is the counter, the prescaler phase, the mode lock and the two flags. A corrupted counter or a prescaler off by one shows up in the status count on the very next read after a known number of reference edges. It also moves the underflow pulse by a whole tick. A lock that fails to hold shows at once in the mode readback and in the reloaded count. A wrong window comparison shows within one cycle of a restart, as a pulse where none belongs or a reload that does not happen.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  // Strobes from control to datapath, valid for one clk cycle.
  typedef struct packed {
    logic tick;      // step the counter
    logic reload;    // load reloadVal (mode write or in-window restart)
    logic winFault;  // keyed restart outside the window
    logic clrFlags;  // status read
  } wdtStrobe_t;

endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int PRESCALE = 128,
  parameter int DATA_W   = 32,
  parameter logic [7:0] KEY = 8'hA5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowClk,
  input  logic              dbgIn,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CNT_W-1:0]  count,
  input  logic              underflowFlag,
  input  logic              windowErrFlag,
  output logic [DATA_W-1:0] rdData,
  output wdtStrobe_t        strobe,
  output logic [CNT_W-1:0]  reloadVal,
  output logic              resetEn
);

  localparam int PRE_W     = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int RSTEN_BIT = CNT_W;
  localparam int HALT_BIT  = CNT_W + 1;
  localparam int DIS_BIT   = CNT_W + 2;
  localparam int DELTA_LSB = DATA_W / 2;
  localparam int CNT_LSB   = DATA_W / 2;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  // slow clock synchronizer and rising-edge detect
  logic [2:0] slowSync;
  logic       slowRise;

  always_ff @(posedge clk) begin
    if (!rstN) slowSync <= '0;
    else       slowSync <= {slowSync[1:0], slowClk};
  end
  assign slowRise = slowSync[1] & ~slowSync[2];

  // prescaler
  logic [PRE_W-1:0] presc;
  logic             prescWrap;

  assign prescWrap = slowRise && (presc == PRE_LAST);

  always_ff @(posedge clk) begin
    if (!rstN)         presc <= '0;
    else if (prescWrap) presc <= '0;
    else if (slowRise)  presc <= presc + 1'b1;
  end

  // write-once mode register
  logic [CNT_W-1:0] reloadReg;
  logic [CNT_W-1:0] deltaReg;
  logic             rstEnReg;
  logic             haltEnReg;
  logic             disReg;
  logic             locked;
  logic             modeWr;

  assign modeWr = wrEn && (addr == ADDR_MODE) && !locked;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadReg <= '1;
      deltaReg  <= '1;
      rstEnReg  <= 1'b1;
      haltEnReg <= 1'b0;
      disReg    <= 1'b0;
      locked    <= 1'b0;
    end else if (modeWr) begin
      reloadReg <= wrData[CNT_W-1:0];
      deltaReg  <= wrData[DELTA_LSB +: CNT_W];
      rstEnReg  <= wrData[RSTEN_BIT];
      haltEnReg <= wrData[HALT_BIT];
      disReg    <= wrData[DIS_BIT];
      locked    <= 1'b1;
    end
  end

  // keyed restart and window check
  logic keyedRestart;
  logic inWindow;

  assign keyedRestart = wrEn && (addr == ADDR_CTRL) && wrData[0]
                        && (wrData[DATA_W-1 -: 8] == KEY) && !disReg;
  assign inWindow     = (count <= deltaReg);

  always_comb begin
    strobe.tick     = prescWrap && !disReg && !(haltEnReg && dbgIn);
    strobe.reload   = modeWr || (keyedRestart && inWindow);
    strobe.winFault = keyedRestart && !inWindow;
    strobe.clrFlags = rdEn && (addr == ADDR_STAT);
  end

  assign reloadVal = modeWr ? wrData[CNT_W-1:0] : reloadReg;
  assign resetEn   = rstEnReg;

  // read mux
  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_MODE: begin
        rdData[CNT_W-1:0]             = reloadReg;
        rdData[RSTEN_BIT]             = rstEnReg;
        rdData[HALT_BIT]              = haltEnReg;
        rdData[DIS_BIT]               = disReg;
        rdData[DELTA_LSB +: CNT_W]    = deltaReg;
      end
      ADDR_STAT: begin
        rdData[0]                     = underflowFlag;
        rdData[1]                     = windowErrFlag;
        rdData[CNT_LSB +: CNT_W]      = count;
      end
      default: rdData = '0;
    endcase
  end

  logic unusedWrBits;
  assign unusedWrBits = ^wrData;

  AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> ($stable(reloadReg) && $stable(deltaReg) && $stable(disReg))); // R3

  AST_DISABLED_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    disReg |-> !strobe.tick); // R5

  AST_HALT_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (haltEnReg && dbgIn) |-> !strobe.tick); // R7

  AST_RESTART_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.winFault |-> !strobe.reload); // R9

endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdtStrobe_t       strobe,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic             resetEn,
  output logic [CNT_W-1:0] count,
  output logic             underflowFlag,
  output logic             windowErrFlag,
  output logic             wdtReset
);

  logic underflow;

  assign underflow = strobe.tick && !strobe.reload && (count == '0);

  always_ff @(posedge clk) begin
    if (!rstN)              count <= '1;
    else if (strobe.reload) count <= reloadVal;
    else if (underflow)     count <= reloadVal;
    else if (strobe.tick)   count <= count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      underflowFlag <= 1'b0;
      windowErrFlag <= 1'b0;
      wdtReset      <= 1'b0;
    end else begin
      underflowFlag <= underflow       | (underflowFlag & ~strobe.clrFlags);
      windowErrFlag <= strobe.winFault | (windowErrFlag & ~strobe.clrFlags);
      wdtReset      <= resetEn & (underflow | strobe.winFault);
    end
  end

  AST_UNDERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && !strobe.reload && count == '0) |=> underflowFlag); // R6

  AST_NO_PULSE_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    !resetEn |=> !wdtReset); // R6

  AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reload |=> (count == $past(reloadVal))); // R8

  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.tick && !strobe.reload) |=> $stable(count)); // R2

endmodule

// File: rtl/watchdog_window.sv
module watchdog_window
  import wdt_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int PRESCALE = 128,
  parameter int DATA_W   = 32,
  parameter logic [7:0] KEY = 8'hA5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowClk,
  input  logic              dbgIn,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              wdtReset,
  output logic              underflowFlag,
  output logic              windowErrFlag
);

  wdtStrobe_t       strobe;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] reloadVal;
  logic             resetEn;

  wdt_ctrl #(
    .CNT_W(CNT_W), .PRESCALE(PRESCALE), .DATA_W(DATA_W), .KEY(KEY)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .slowClk(slowClk), .dbgIn(dbgIn),
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .count(count), .underflowFlag(underflowFlag), .windowErrFlag(windowErrFlag),
    .rdData(rdData), .strobe(strobe), .reloadVal(reloadVal), .resetEn(resetEn)
  );

  wdt_datapath #(.CNT_W(CNT_W)) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reloadVal(reloadVal),
    .resetEn(resetEn), .count(count), .underflowFlag(underflowFlag),
    .windowErrFlag(windowErrFlag), .wdtReset(wdtReset)
  );

endmodule

// File: tb/watchdog_window_bench.sv
module watchdog_window_bench;

  localparam int PRE = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        slowClk = 1'b0;
  logic        dbgIn = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wrData = 32'd0;
  logic [31:0] rdData;
  logic        wdtReset;
  logic        underflowFlag;
  logic        windowErrFlag;

  always #4 clk = ~clk;

  watchdog_window #(.PRESCALE(PRE)) u_watchdog_window (
    .clk(clk), .rstN(rstN), .slowClk(slowClk), .dbgIn(dbgIn),
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .wdtReset(wdtReset),
    .underflowFlag(underflowFlag), .windowErrFlag(windowErrFlag)
  );

  int checks = 0;
  int errors = 0;
  int pulseCnt = 0;
  bit finished = 1'b0;

  logic [31:0] expQ[$];
  string       tagQ[$];

  always @(negedge clk) if (wdtReset) pulseCnt++;

  // monitor: pops the scoreboard on each read
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rdEn && expQ.size() > 0) begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checks++;
        if (rdData !== e) begin
          errors++;
          $display("FAIL %s read addr %0d actual %h expected %h", t, addr, rdData, e);
        end
      end
    end
  end

  task automatic checkVal(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic readExpect(input logic [1:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    addr = a;
    rdEn = 1'b1;
    expQ.push_back(e);
    tagQ.push_back(tag);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a;
    wrData = d;
    wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic slowEdges(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slowClk = 1'b1;
      repeat (2) @(negedge clk); slowClk = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic doReset();
    slowClk = 1'b0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    // ---- phase 1: defaults, write-once, prescale, restart key, underflow
    doReset();
    checkVal("R1 wdtReset after reset", wdtReset, 0);
    checkVal("R1 underflowFlag after reset", underflowFlag, 0);
    readExpect(2'd2, 32'h0FFF_0000, "R1 status after reset");
    readExpect(2'd0, 32'h0FFF_1FFF, "R1 mode after reset");
    dbgIn = 1'b1; // debug halt bit clear: must not matter (R7)
    writeReg(2'd0, 32'h0FFF_1014);
    readExpect(2'd2, 32'h0014_0000, "R3 first mode write reloads count");
    writeReg(2'd0, 32'h0FFF_1005);
    readExpect(2'd0, 32'h0FFF_1014, "R3 R4 second mode write ignored");
    readExpect(2'd2, 32'h0014_0000, "R3 count untouched by second write");
    slowEdges(2 * PRE);
    readExpect(2'd2, 32'h0012_0000, "R2 R7 two ticks with dbgIn high");
    slowEdges(PRE - 1);
    readExpect(2'd2, 32'h0012_0000, "R2 partial prescale no tick");
    slowEdges(1);
    readExpect(2'd2, 32'h0011_0000, "R2 prescale completes");
    writeReg(2'd1, 32'h5A00_0001);
    readExpect(2'd2, 32'h0011_0000, "R8 wrong key ignored");
    writeReg(2'd1, 32'hA500_0000);
    readExpect(2'd2, 32'h0011_0000, "R8 restart bit clear ignored");
    writeReg(2'd1, 32'hA500_0001);
    readExpect(2'd2, 32'h0014_0000, "R8 R9 keyed restart any-window reloads");
    dbgIn = 1'b0;
    base = pulseCnt;
    slowEdges(21 * PRE);
    checkVal("R6 one reset pulse at underflow", pulseCnt - base, 1);
    checkVal("R6 underflowFlag port", underflowFlag, 1);
    readExpect(2'd2, 32'h0014_0001, "R6 R10 underflow reloads and flags");
    readExpect(2'd2, 32'h0014_0000, "R10 read clears flags");

    // ---- phase 2: window
    doReset();
    writeReg(2'd0, 32'h000A_101E);
    base = pulseCnt;
    writeReg(2'd1, 32'hA500_0001);
    checkVal("R9 early restart pulses reset", pulseCnt - base, 1);
    checkVal("R9 windowErrFlag port", windowErrFlag, 1);
    readExpect(2'd2, 32'h001E_0002, "R9 early restart no reload");
    slowEdges(20 * PRE);
    readExpect(2'd2, 32'h000A_0000, "R2 counted to window edge");
    base = pulseCnt;
    writeReg(2'd1, 32'hA500_0001);
    readExpect(2'd2, 32'h001E_0000, "R9 restart inside window reloads");
    checkVal("R9 no pulse inside window", pulseCnt - base, 0);

    // ---- phase 3: disable
    doReset();
    writeReg(2'd0, 32'h0FFF_5014);
    base = pulseCnt;
    slowEdges(25 * PRE);
    readExpect(2'd2, 32'h0014_0000, "R5 disabled counter frozen");
    checkVal("R5 no pulse when disabled", pulseCnt - base, 0);

    // ---- phase 4: debug halt, reset enable off
    doReset();
    writeReg(2'd0, 32'h0FFF_2003);
    dbgIn = 1'b1;
    slowEdges(3 * PRE);
    readExpect(2'd2, 32'h0003_0000, "R7 halted in debug");
    dbgIn = 1'b0;
    base = pulseCnt;
    slowEdges(4 * PRE);
    readExpect(2'd2, 32'h0003_0001, "R6 underflow flagged with reset off");
    checkVal("R6 no pulse with reset enable clear", pulseCnt - base, 0);

    repeat (4) @(negedge clk);
    checkVal("scoreboard drained", expQ.size(), 0);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule